// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Registers

This block keeps time of day and calendar in packed BCD: seconds, minutes, hours (24-hour), day of week, date, month, year and century. A one-second enable is derived by dividing a slow tick input, nominally one pulse per 32.768 kHz period, by a parameter. The counting copy of the time lives inside the block and never stops while the oscillator is enabled. A second copy is the one a host reads and writes through a byte-wide register port, sixteen offsets wide, which sits at the top of a larger RAM-style address map.

Two control bits govern how the copies interact. The freeze bit holds the visible copy still so a multi-byte read is consistent while the internal count keeps running; once it is released, the visible copy catches up on the next second. The load bit also stops visible updates so new values can be written; clearing it copies the visible values into the internal counters and restarts the sub-second divider. A stop bit in the seconds register halts the counters entirely, and it is set after reset.

Top module: `rtc_dbuf_regs`

## Requirements
- R1: After reset the registers read: seconds 0x80 (stop bit set, count 00), minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00, control 0x20 (century 20, both control bits clear).
- R2: Register offsets: 0x8 control (bit 7 load bit, bit 6 freeze bit, bits 5:0 century), 0x9 seconds (bit 7 stop bit, bits 6:0 seconds), 0xA minutes, 0xB hours, 0xC day of week, 0xD date, 0xE month, 0xF year; read data appears on the clock edge after the offset is presented.
- R3: Offsets 0x0 to 0x7 always read 0x00 and writes to them change nothing.
- R4: With the stop bit clear, every TICKS_PER_SEC tick pulses advance the seconds by one in BCD, with carries into minutes at 59 and into hours at 59 minutes; hours wrap from 23 to 00.
- R5: At an hour wrap the day of week steps 1..7 and wraps to 1, and the date wraps to 01 after 28 (February, year not divisible by 4), 29 (February, year divisible by 4, year 00 included), 30 (April, June, September, November) or 31 (other months); a month wrap after 12 advances the year, and a year wrap after 99 advances the century.
- R6: With the stop bit set the internal counters hold their values.
- R7: While the freeze bit is 1 the visible registers do not follow the count, which continues internally; after the bit is cleared the visible copy shows the running count from the next second onward.
- R8: While the load bit is 1 the visible registers do not follow the count; writing the control register with bit 7 = 0 while the load bit is 1 copies the visible values and the newly written century into the internal counters and restarts the sub-second divider.
- R9: With both control bits clear the visible copy takes the new count in the same cycle the internal counters advance.
- R10: Field values written outside BCD range are kept as written; a field at or above its last legal value wraps to its first value and carries on the next step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | One-cycle pulse per oscillator period |
| reg_addr | input | 4 | Register offset within the clock window |
| reg_we | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's offset |

## Verification
On every cycle the checker confirms that a stopped oscillator holds the internal count, that a set freeze bit keeps the visible seconds still, that with both control bits clear the visible minutes equal the internal count after each second step, that a transfer lands the visible hours in the counters, and that unmapped offsets read zero. Month lengths across leap and common years, weekday and century wraps, recovery from out-of-range values, and the catch-up of the visible copy after a freeze can only be seen in the bench scenarios, which load boundary times and compare readback with arithmetically computed calendars.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] day;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] yr;
    logic [7:0] cen;
  } rtc_time_t;

  // BCD step with wrap: at or above last legal value -> first value
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] last,
                                          input logic [7:0] first);
    if (v >= last)            return first;
    else if (v[3:0] >= 4'd9)  return {v[7:4] + 4'd1, 4'h0};
    else                      return v + 8'd1;
  endfunction

  function automatic logic yr_is_leap(input logic [7:0] yr);
    logic [7:0] bin;
    bin = ({4'b0, yr[7:4]} * 8'd10) + {4'b0, yr[3:0]};
    return (bin[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr);
    case (mon)
      8'h02:                      return yr_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  input  logic run,
  input  logic restart,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign sec_pulse = run && tick_in && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt_q <= '0;
    else if (tick_in)           cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_count_chain.sv
module rtc_count_chain
  import rtc_pkg::*;
#(
  parameter rtc_time_t RST_VAL = '0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sec_pulse,
  input  logic      load,
  input  rtc_time_t ld_val,
  output rtc_time_t cnt_q,
  output rtc_time_t cnt_nxt
);
  logic c_sec, c_min, c_hr, c_date, c_mon, c_yr;
  logic [7:0] last_day;

  always_comb begin
    last_day = month_last_day(cnt_q.mon, cnt_q.yr);
    c_sec  = (cnt_q.sec  >= 8'h59);
    c_min  = c_sec  && (cnt_q.min  >= 8'h59);
    c_hr   = c_min  && (cnt_q.hr   >= 8'h23);
    c_date = c_hr   && (cnt_q.date >= last_day);
    c_mon  = c_date && (cnt_q.mon  >= 8'h12);
    c_yr   = c_mon  && (cnt_q.yr   >= 8'h99);

    cnt_nxt      = cnt_q;
    cnt_nxt.sec  = bcd_step(cnt_q.sec, 8'h59, 8'h00);
    if (c_sec)  cnt_nxt.min  = bcd_step(cnt_q.min,  8'h59, 8'h00);
    if (c_min)  cnt_nxt.hr   = bcd_step(cnt_q.hr,   8'h23, 8'h00);
    if (c_hr)   cnt_nxt.day  = bcd_step(cnt_q.day,  8'h07, 8'h01);
    if (c_hr)   cnt_nxt.date = bcd_step(cnt_q.date, last_day, 8'h01);
    if (c_date) cnt_nxt.mon  = bcd_step(cnt_q.mon,  8'h12, 8'h01);
    if (c_mon)  cnt_nxt.yr   = bcd_step(cnt_q.yr,   8'h99, 8'h00);
    if (c_yr)   cnt_nxt.cen  = bcd_step(cnt_q.cen,  8'h39, 8'h00);
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= RST_VAL;
    else if (load)      cnt_q <= ld_val;
    else if (sec_pulse) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/rtc_dbuf_regs.sv
module rtc_dbuf_regs
  import rtc_pkg::*;
#(
  parameter int         TICKS_PER_SEC = 32768,
  parameter logic [5:0] CEN_RESET     = 6'h20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_in,
  input  logic [3:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam rtc_time_t RST_TIME = '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                                     day: 8'h01, date: 8'h01, mon: 8'h01,
                                     yr: 8'h00, cen: {2'b00, CEN_RESET}};
  localparam logic [3:0] OFS_CTRL = 4'h8;
  localparam logic [3:0] OFS_SEC  = 4'h9;
  localparam logic [3:0] OFS_MIN  = 4'hA;
  localparam logic [3:0] OFS_HR   = 4'hB;
  localparam logic [3:0] OFS_DAY  = 4'hC;
  localparam logic [3:0] OFS_DATE = 4'hD;
  localparam logic [3:0] OFS_MON  = 4'hE;
  localparam logic [3:0] OFS_YR   = 4'hF;

  rtc_time_t ext_q, cnt_q, cnt_nxt, ld_val;
  logic osc_stop, ctrl_r, ctrl_w;
  logic sec_pulse, load, follow;

  assign load   = reg_we && (reg_addr == OFS_CTRL) && ctrl_w && !reg_wdata[7];
  assign follow = sec_pulse && !ctrl_r && !ctrl_w;

  always_comb begin
    ld_val     = ext_q;
    ld_val.cen = {2'b00, reg_wdata[5:0]};
  end

  rtc_sec_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst(rst), .tick_in(tick_in), .run(!osc_stop),
    .restart(load), .sec_pulse(sec_pulse)
  );

  rtc_count_chain #(.RST_VAL(RST_TIME)) u_chain (
    .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .load(load),
    .ld_val(ld_val), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  // Visible copy: follows the count unless frozen; host writes win
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q    <= RST_TIME;
      osc_stop <= 1'b1;
      ctrl_r   <= 1'b0;
      ctrl_w   <= 1'b0;
    end else begin
      if (follow) ext_q <= cnt_nxt;
      if (reg_we) begin
        case (reg_addr)
          OFS_CTRL: begin
            ctrl_w    <= reg_wdata[7];
            ctrl_r    <= reg_wdata[6];
            ext_q.cen <= {2'b00, reg_wdata[5:0]};
          end
          OFS_SEC: begin
            osc_stop  <= reg_wdata[7];
            ext_q.sec <= {1'b0, reg_wdata[6:0]};
          end
          OFS_MIN:  ext_q.min  <= reg_wdata;
          OFS_HR:   ext_q.hr   <= reg_wdata;
          OFS_DAY:  ext_q.day  <= reg_wdata;
          OFS_DATE: ext_q.date <= reg_wdata;
          OFS_MON:  ext_q.mon  <= reg_wdata;
          OFS_YR:   ext_q.yr   <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 8'h00;
    else begin
      case (reg_addr)
        OFS_CTRL: reg_rdata <= {ctrl_w, ctrl_r, ext_q.cen[5:0]};
        OFS_SEC:  reg_rdata <= {osc_stop, ext_q.sec[6:0]};
        OFS_MIN:  reg_rdata <= ext_q.min;
        OFS_HR:   reg_rdata <= ext_q.hr;
        OFS_DAY:  reg_rdata <= ext_q.day;
        OFS_DATE: reg_rdata <= ext_q.date;
        OFS_MON:  reg_rdata <= ext_q.mon;
        OFS_YR:   reg_rdata <= ext_q.yr;
        default:  reg_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rtc_dbuf_checker.sv
module rtc_dbuf_checker
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [3:0] reg_addr,
  input logic       reg_we,
  input logic [7:0] reg_rdata,
  input logic       osc_stop,
  input logic       ctrl_r,
  input logic       ctrl_w,
  input logic       load,
  input logic       sec_pulse,
  input rtc_time_t  cnt_q,
  input rtc_time_t  ext_q
);
  // R6: stopped oscillator holds the internal counters
  p_stop_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (osc_stop && !load) |=> $stable(cnt_q));

  // R7: frozen visible seconds do not move unless the host writes them
  p_freeze_sec_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_r && !(reg_we && reg_addr == 4'h9)) |=> $stable(ext_q.sec));

  // R9: visible minutes track the count on each second step
  p_follow_min_r9: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !ctrl_r && !ctrl_w && !(reg_we && reg_addr == 4'hA))
    |=> (ext_q.min == cnt_q.min));

  // R8: transfer lands visible hours in the counters
  p_load_hr_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q.hr == $past(ext_q.hr)));

  // R3: low offsets read zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !reg_addr[3] |=> (reg_rdata == 8'h00));
endmodule

bind rtc_dbuf_regs rtc_dbuf_checker u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_rdata(reg_rdata), .osc_stop(osc_stop), .ctrl_r(ctrl_r),
  .ctrl_w(ctrl_w), .load(load), .sec_pulse(sec_pulse),
  .cnt_q(cnt_q), .ext_q(ext_q)
);

// File: tb/rtc_dbuf_regs_bench.sv
module rtc_dbuf_regs_bench;
  localparam int TPS = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_dbuf_regs #(.TICKS_PER_SEC(TPS), .CEN_RESET(6'h20)) u_rtc_dbuf_regs (
    .clk(clk), .rst(rst), .tick_in(tick_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic seconds(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_in = 1'b1;
      repeat (TPS) @(posedge clk);
      @(negedge clk);
      tick_in = 1'b0;
    end
  endtask

  task automatic load_time(input logic [7:0] cen, input logic [7:0] yr,
                           input logic [7:0] mon, input logic [7:0] dt,
                           input logic [7:0] dy, input logic [7:0] hr,
                           input logic [7:0] mn, input logic [7:0] sc);
    wr(4'h8, 8'h80 | cen);
    wr(4'hF, yr); wr(4'hE, mon); wr(4'hD, dt); wr(4'hC, dy);
    wr(4'hB, hr); wr(4'hA, mn); wr(4'h9, sc);
    wr(4'h8, cen & 8'h3F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state, R2 layout
    expect_reg("R1 sec",  4'h9, 8'h80);
    expect_reg("R1 min",  4'hA, 8'h00);
    expect_reg("R1 hr",   4'hB, 8'h00);
    expect_reg("R1 day",  4'hC, 8'h01);
    expect_reg("R1 date", 4'hD, 8'h01);
    expect_reg("R1 mon",  4'hE, 8'h01);
    expect_reg("R1 yr",   4'hF, 8'h00);
    expect_reg("R1 ctrl", 4'h8, 8'h20);

    // R6 stopped from reset: no counting
    seconds(3);
    expect_reg("R6 stopped at reset", 4'h9, 8'h80);

    // R3 low offsets ignored
    for (int a = 0; a < 8; a++) begin
      wr(4'(a), 8'hA5);
      expect_reg("R3 unmapped", 4'(a), 8'h00);
    end
    expect_reg("R3 no side effect min", 4'hA, 8'h00);

    // R4/R9 counting sweep: 0..3 minutes, every second
    load_time(8'h20, 8'h24, 8'h03, 8'h10, 8'h02, 8'h05, 8'h00, 8'h00);
    for (int t = 1; t <= 200; t++) begin
      seconds(1);
      expect_reg("R4 R9 sec", 4'h9, bcd(t % 60));
      if (t % 60 == 0) expect_reg("R4 min carry", 4'hA, bcd(t / 60));
    end

    // R4 hour wrap 23:59:59 -> 00:00:00, R2 layout of hours
    load_time(8'h20, 8'h24, 8'h03, 8'h10, 8'h02, 8'h23, 8'h59, 8'h59);
    seconds(1);
    expect_reg("R4 hr wrap",  4'hB, 8'h00);
    expect_reg("R4 min wrap", 4'hA, 8'h00);
    expect_reg("R5 day step", 4'hC, 8'h03);

    // R5 month-end sweep over common, leap, and year-00 cases
    for (int yi = 0; yi < 3; yi++) begin
      int y;
      y = (yi == 0) ? 23 : (yi == 1) ? 24 : 0;
      for (int m = 1; m <= 12; m++) begin
        int d;
        d = mdays(m, y);
        load_time(8'h20, bcd(y), bcd(m), bcd(d - 1), 8'h03, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_reg("R5 no early wrap", 4'hD, bcd(d));
        load_time(8'h20, bcd(y), bcd(m), bcd(d), 8'h07, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_reg("R5 date wrap", 4'hD, 8'h01);
        expect_reg("R5 month", 4'hE, bcd(m % 12 + 1));
        expect_reg("R5 year", 4'hF, bcd((m == 12) ? y + 1 : y));
        expect_reg("R5 weekday wrap", 4'hC, 8'h01);
      end
    end

    // R5 century
    load_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    seconds(1);
    expect_reg("R5 year 99 wrap", 4'hF, 8'h00);
    expect_reg("R5 century", 4'h8, 8'h21);

    // R7 freeze, internal continues, catch-up after release
    load_time(8'h20, 8'h24, 8'h06, 8'h01, 8'h01, 8'h10, 8'h00, 8'h10);
    wr(4'h8, 8'h60);
    seconds(3);
    expect_reg("R7 frozen", 4'h9, 8'h10);
    wr(4'h8, 8'h20);
    expect_reg("R7 still old before tick", 4'h9, 8'h10);
    seconds(1);
    expect_reg("R7 catch-up", 4'h9, 8'h14);

    // R8 load bit halts visible copy; transfer on clear
    wr(4'h8, 8'hA0);
    seconds(2);
    expect_reg("R8 halted", 4'h9, 8'h14);
    wr(4'h9, 8'h30);
    wr(4'hB, 8'h07);
    wr(4'h8, 8'h22);
    seconds(1);
    expect_reg("R8 sec loaded", 4'h9, 8'h31);
    expect_reg("R8 hr loaded", 4'hB, 8'h07);
    expect_reg("R8 century loaded", 4'h8, 8'h22);

    // R6 stop bit set via load holds count
    load_time(8'h20, 8'h24, 8'h06, 8'h01, 8'h01, 8'h10, 8'h00, 8'h85);
    seconds(4);
    expect_reg("R6 stop holds", 4'h9, 8'h85);
    wr(4'h8, 8'h80);
    wr(4'h9, 8'h05);
    wr(4'h8, 8'h20);
    seconds(2);
    expect_reg("R6 restart", 4'h9, 8'h07);

    // R10 invalid values wrap
    load_time(8'h20, 8'h24, 8'h06, 8'h01, 8'h01, 8'h10, 8'h00, 8'h5A);
    expect_reg("R10 stored as written", 4'h9, 8'h5A);
    seconds(1);
    expect_reg("R10 sec wrap", 4'h9, 8'h00);
    expect_reg("R10 min carry", 4'hA, 8'h01);
    load_time(8'h20, 8'h24, 8'h06, 8'h01, 8'h01, 8'h2F, 8'h59, 8'h59);
    seconds(1);
    expect_reg("R10 hr wrap", 4'hB, 8'h00);
    expect_reg("R10 day carry", 4'hD, 8'h02);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule